// File: doc/BRIEF.md
# Sixty-Second Stopwatch Core

This block keeps a seconds count from 00 to 59 as two BCD digits, a units digit that cycles through 0 to 9 and a tens digit that cycles through 0 to 5. Everything runs on one system clock. A single-cycle strobe, produced outside the block once per second, moves the count forward by one, but only while the run state is set.

The run state flips once for each rising edge seen on the start/stop button level. A clear button, active low and sampled as a level, zeroes both digits for as long as it is held and also drops the run state, so the user must press start/stop again after releasing it. After the asynchronous system reset the block is stopped and reads 00. Debouncing, generation of the one-second strobe and display decoding are done outside the block.

Top module: `stopwatch_core`

## Requirements
- R1: After rst_ni is deasserted and before any input activity, ones_o and tens_o read 0 and running_o reads 0.
- R2: While running_o is 0, a high tick_i leaves ones_o and tens_o unchanged.
- R3: Each 0-to-1 transition of start_i that is sampled while clear_ni is high inverts running_o at that clock edge. Holding start_i high does not invert it again.
- R4: On a clock edge where tick_i is 1 and running_o is 1, ones_o increases by exactly one when it was below 9. On edges where tick_i is 0, ones_o and tens_o do not change.
- R5: A counting edge with ones_o at 9 sets ones_o to 0 and increases tens_o by one on that same edge. tens_o changes only on such edges or on a clear.
- R6: A counting edge at a count of 59 (tens_o 5, ones_o 9) returns the count to 00.
- R7: While clear_ni is 0, the edge sets ones_o and tens_o to 0 and running_o to 0. This holds even when a start_i rising edge arrives in the same cycle.
- R8: After a stop, the count stays frozen under further ticks. The next start resumes counting from that frozen value.
- R9: ones_o never exceeds 9 and tens_o never exceeds 5, in BCD with bit 0 as the least significant bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous system reset, active low |
| tick_i | input | 1 | One-second strobe, one cycle wide |
| clear_ni | input | 1 | Clear push-button level, active low, synchronous |
| start_i | input | 1 | Start/stop push-button level, already debounced |
| ones_o | output | 4 | Units digit of seconds, BCD |
| tens_o | output | 4 | Tens digit of seconds, BCD |
| running_o | output | 1 | 1 while the count is allowed to advance |

## Verification
Two cases are hard to reach from the ports. The first is the rollover from 59 to 00, which needs sixty counting edges in a row with no stop or clear in between. The second is a clear arriving in the same cycle as a start/stop rising edge. The bench drives both on purpose: a directed run of running ticks that passes through 09 and 59, and a cycle that asserts clear_ni together with a fresh start_i edge. It then runs long stretches of seeded random ticks, presses and rare clears, so that the wraps are crossed many times from states where the stopwatch was paused and resumed.

// File: rtl/stopwatch_pkg.sv
package stopwatch_pkg;
  localparam int DIGIT_W    = 4;
  localparam int NUM_DIGITS = 2;

  // modulus of each decimal position, least significant first
  function automatic int digit_modulus(input int idx);
    return (idx == 0) ? 10 : 6;
  endfunction
endpackage

// File: rtl/sw_run_ctrl.sv
module sw_run_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic button_i,
  output logic run_o
);
  logic button_q;
  logic press;

  assign press = button_i & ~button_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      button_q <= 1'b0;
      run_o    <= 1'b0;
    end else begin
      button_q <= button_i;
      if (clear_i)    run_o <= 1'b0;   // clear wins over a press
      else if (press) run_o <= ~run_o;
    end
  end

  p_clear_stops_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !run_o);
  p_press_flips_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && button_i && !button_q) |=> (run_o != $past(run_o)));
  p_held_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !(button_i && !button_q)) |=> $stable(run_o));
endmodule

// File: rtl/sw_digit.sv
module sw_digit #(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [WIDTH-1:0] value_o,
  output logic             wrap_o
);
  localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

  logic at_last;
  assign at_last = (value_o == LAST);
  assign wrap_o  = step_i & at_last & ~clear_i;

  // terminal value decoded synchronously: no transient illegal code
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      value_o <= '0;
    else if (clear_i) value_o <= '0;
    else if (step_i)  value_o <= at_last ? '0 : value_o + WIDTH'(1);
  end

  p_in_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    value_o <= LAST);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !step_i) |=> $stable(value_o));
  p_wrap_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (value_o == '0));
  p_step_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && step_i && $past(1'b1) && value_o != LAST)
      |=> (value_o == $past(value_o) + WIDTH'(1)));
endmodule

// File: rtl/stopwatch_core.sv
module stopwatch_core
  import stopwatch_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               clear_ni,
  input  logic               start_i,
  output logic [DIGIT_W-1:0] ones_o,
  output logic [DIGIT_W-1:0] tens_o,
  output logic               running_o
);
  logic                              clear;
  logic                              run;
  logic [NUM_DIGITS:0]               carry;
  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] digit_q;

  assign clear    = ~clear_ni;
  assign carry[0] = tick_i & run;

  sw_run_ctrl u_run (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .button_i(start_i),
    .run_o   (run)
  );

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
    sw_digit #(
      .WIDTH  (DIGIT_W),
      .MODULUS(digit_modulus(d))
    ) u_digit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clear_i(clear),
      .step_i (carry[d]),
      .value_o(digit_q[d]),
      .wrap_o (carry[d+1])
    );
  end

  assign ones_o    = digit_q[0];
  assign tens_o    = digit_q[1];
  assign running_o = run;

  p_clear_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_ni |=> (ones_o == '0 && tens_o == '0 && !running_o));
  p_rollover_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry[NUM_DIGITS] |=> (ones_o == '0 && tens_o == '0));
  p_tens_moves_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_ni && !(tick_i && running_o && ones_o == 4'd9)) |=> $stable(tens_o));
  p_stopped_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_ni && !running_o) |=> ($stable(ones_o) && $stable(tens_o)));
endmodule

// File: tb/stopwatch_core_tb_top.sv
module stopwatch_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       clr_n = 1'b1;
  logic       start = 1'b0;
  logic [3:0] ones, tens;
  logic       running;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  logic [9:0]  mdl = '0;  // {run, start_prev, tens, ones}

  always #2.5 clk = ~clk;

  stopwatch_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .clear_ni(clr_n),
    .start_i(start), .ones_o(ones), .tens_o(tens), .running_o(running)
  );

  function automatic logic [9:0] nxt(input logic [9:0] s, input logic tk,
                                     input logic cn, input logic st);
    logic       r  = s[9];
    logic       pv = s[8];
    logic [3:0] t  = s[7:4];
    logic [3:0] o  = s[3:0];
    if (!cn) begin
      o = 4'd0; t = 4'd0; r = 1'b0;
    end else begin
      if (tk && r) begin
        if (o == 4'd9) begin
          o = 4'd0;
          t = (t == 4'd5) ? 4'd0 : t + 4'd1;
        end else o = o + 4'd1;
      end
      if (st && !pv) r = ~r;
    end
    return {r, st, t, o};
  endfunction

  task automatic check(input string tag);
    n_cmp++;
    if (ones !== mdl[3:0] || tens !== mdl[7:4] || running !== mdl[9]
        || ones > 4'd9 || tens > 4'd5) begin
      n_bad++;
      $display("FAIL %s: got t=%0d o=%0d run=%0b exp t=%0d o=%0d run=%0b",
               tag, tens, ones, running, mdl[7:4], mdl[3:0], mdl[9]);
    end
  endtask

  // drive at negedge, model across the posedge, compare at next negedge
  task automatic step(input logic tk, input logic cn, input logic st, input string tag);
    tick = tk; clr_n = cn; start = st;
    @(posedge clk);
    mdl = nxt(mdl, tk, cn, st);
    @(negedge clk);
    check(tag);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(5ns * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state");

    repeat (3) step(1'b1, 1'b1, 1'b0, "R2 tick while stopped");

    step(1'b0, 1'b1, 1'b1, "R3 press starts");
    repeat (3) step(1'b0, 1'b1, 1'b1, "R3 held button");
    step(1'b0, 1'b1, 1'b0, "R3 release");

    for (int i = 0; i < 9; i++) begin
      step(1'b1, 1'b1, 1'b0, "R4 ones step");
      step(1'b0, 1'b1, 1'b0, "R4 no tick");
    end
    step(1'b1, 1'b1, 1'b0, "R5 09 to 10");
    for (int i = 0; i < 49; i++) step(1'b1, 1'b1, 1'b0, "R5 run to 59");
    step(1'b1, 1'b1, 1'b0, "R6 59 to 00");
    repeat (23) step(1'b1, 1'b1, 1'b0, "R4 run on");

    step(1'b0, 1'b1, 1'b1, "R8 stop");
    step(1'b0, 1'b1, 1'b0, "R8 release");
    repeat (5) step(1'b1, 1'b1, 1'b0, "R8 frozen");
    step(1'b1, 1'b1, 1'b1, "R8 restart");
    step(1'b1, 1'b1, 1'b0, "R8 resumed");

    step(1'b0, 1'b1, 1'b0, "R7 prep");
    step(1'b1, 1'b0, 1'b1, "R7 clear beats press");
    repeat (3) step(1'b1, 1'b0, 1'b0, "R7 clear held");
    step(1'b1, 1'b1, 1'b0, "R7 stays stopped");

    for (int i = 0; i < 6000; i++) begin
      logic tk = ($urandom % 4) != 0;
      logic cn = ($urandom % 300) != 0;
      logic st = ($urandom % 40) == 0 ? ~start : start;
      step(tk, cn, st, "R9 random");
    end
    finish_run();
  end
endmodule